// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog countdown controlled by a single control register written over a simple write port. Each write carries three fields: a timeout count, a run/stop command and a 7-bit key. Once the watchdog runs, software must prove it is alive. Each kick must carry the bitwise inverse of the key held from the last accepted write. A write with any other key is dropped without effect.

The counter moves only when the slow tick-enable input is high. If it reaches zero, the block does not reset the system at once. It first raises a non-maskable interrupt and reloads a short grace count. This gives a handler the chance to kick the watchdog or record state. If the grace count also runs out, a one-cycle system reset request is issued. The slow tick source and the actual reset of the system belong to the surrounding chip.

Top module: `kwdog_top`

## Requirements
- R1: After reset, `nmi` and `rst_req` are 0, the counter is stopped so that ticks cause no expiry, and the key check is off.
- R2: Write data field layout: count in bits [7:0], run command in bit 8, key in bits [15:9]. Bits [31:16] have no effect on behaviour.
- R3: While the stored run bit (bit 8) is 1, a write whose key differs from the 7-bit inverse of the stored key is discarded. The countdown and its expiry time are unchanged.
- R4: An accepted write with bit 8 = 1 loads the counter from the written count and runs it. The counter expires on the tick that takes it from 1 to 0, which is the count-th tick after the write.
- R5: A written count of 0 is treated as 256 ticks.
- R6: An accepted write with bit 8 = 0 stops the counter, so later ticks never cause an expiry.
- R7: The counter changes only in cycles where `tick` is 1. Cycles without a tick, however many, do not advance it.
- R8: On the first expiry, `nmi` goes to 1 in the cycle after the expiring tick. The counter reloads with GRACE (default 10) and keeps running.
- R9: An expiry while `nmi` is 1 produces a `rst_req` pulse exactly one cycle long, after GRACE further ticks. The counter then stops and `nmi` stays 1.
- R10: An accepted write clears `nmi` in the following cycle and returns the block to the first expiry stage.
- R11: While the stored run bit is 0, a write with any key is accepted.
- R12: When an accepted write and a tick arrive in the same cycle, the write wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write value |
| tick | input | 1 | Slow tick enable; one counter step per high cycle |
| nmi | output | 1 | Non-maskable interrupt, first expiry stage |
| rst_req | output | 1 | One-cycle system reset request, second expiry stage |

## Verification
The hardest case to reach from the ports is the reset request. It needs a full expiry, then an uninterrupted grace period, with no accepted write along the way. It must also be shown that a badly keyed kick dropped in the middle does not disturb either countdown. The stimulus uses short counts and a wrong-key write made during the countdown that ends in the interrupt. It then counts exactly GRACE ticks to land on the pulse cycle. A behavioural model in the bench tracks stage, count and key, and is compared with both outputs every cycle.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
    typedef enum logic {
        ST_WATCH = 1'b0,
        ST_NMI   = 1'b1
    } wd_stage_e;
endpackage

// File: rtl/kwdog_key_gate.sv
module kwdog_key_gate #(
    parameter int KEY_W = 7
) (
    input  logic             wr_en,
    input  logic             armed,
    input  logic [KEY_W-1:0] stored_key,
    input  logic [KEY_W-1:0] wr_key,
    output logic             accept
);
    logic [KEY_W-1:0] want_key;

    always_comb begin
        want_key = ~stored_key;
        accept   = wr_en && (!armed || (wr_key == want_key));
    end
endmodule

// File: rtl/kwdog_countdown.sv
module kwdog_countdown #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          load_run,
    input  logic          tick,
    input  logic [CW-1:0] reload_val,
    input  logic          reload_run,
    output logic          expire,
    output logic [CW-1:0] count,
    output logic          running
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
            st_d.run = load_run;
        end else if (st_q.run && tick) begin
            if (st_q.cnt == CW'(1)) begin
                expire   = 1'b1;
                st_d.cnt = reload_val;
                st_d.run = reload_run;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top #(
    parameter int REG_W = 32,
    parameter int CNT_W = 8,
    parameter int KEY_W = 7,
    parameter int GRACE = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick,
    output logic             nmi,
    output logic             rst_req
);
    import kwdog_pkg::*;

    localparam int CMD_POS = CNT_W;
    localparam int KEY_LSB = CNT_W + 1;
    localparam int CW      = CNT_W + 1;
    localparam int FULL    = 1 << CNT_W;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        wd_stage_e        stage;
        logic             nmi;
        logic             rreq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CNT_W-1:0] wr_count;
    logic             wr_cmd;
    logic [KEY_W-1:0] wr_key;
    logic [KEY_W-1:0] stored_key;
    logic             armed;
    logic             wr_accept;
    logic [CW-1:0]    load_val;
    logic             expire;
    logic             reload_run;
    logic [CW-1:0]    cnt_q;
    logic             run_q;

    always_comb begin
        wr_count   = wr_data[CNT_W-1:0];
        wr_cmd     = wr_data[CMD_POS];
        wr_key     = wr_data[KEY_LSB +: KEY_W];
        stored_key = st_q.ctrl[KEY_LSB +: KEY_W];
        armed      = st_q.ctrl[CMD_POS];
        load_val   = (wr_count == '0) ? CW'(FULL) : CW'(wr_count);
        reload_run = (st_q.stage == ST_WATCH);
    end

    kwdog_key_gate #(.KEY_W(KEY_W)) u_gate (
        .wr_en      (wr_en),
        .armed      (armed),
        .stored_key (stored_key),
        .wr_key     (wr_key),
        .accept     (wr_accept)
    );

    kwdog_countdown #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_accept),
        .load_val   (load_val),
        .load_run   (wr_cmd),
        .tick       (tick),
        .reload_val (CW'(GRACE)),
        .reload_run (reload_run),
        .expire     (expire),
        .count      (cnt_q),
        .running    (run_q)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rreq = 1'b0;
        if (wr_accept) begin
            st_d.ctrl  = wr_data;
            st_d.stage = ST_WATCH;
            st_d.nmi   = 1'b0;
        end else if (expire) begin
            if (st_q.stage == ST_WATCH) begin
                st_d.stage = ST_NMI;
                st_d.nmi   = 1'b1;
            end else begin
                st_d.rreq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= '0;
            st_q.stage <= ST_WATCH;
            st_q.nmi   <= 1'b0;
            st_q.rreq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi     = st_q.nmi;
    assign rst_req = st_q.rreq;
endmodule

// File: rtl/kwdog_checker.sv
module kwdog_checker #(
    parameter int REG_W = 32,
    parameter int CW    = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             tick,
    input logic             accept,
    input logic [REG_W-1:0] ctrl,
    input logic [CW-1:0]    count,
    input logic             running,
    input logic             nmi,
    input logic             rst_req
);
    assert_rreq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_rreq_after_nmi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> nmi);

    assert_kick_clears_nmi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!nmi && !rst_req));

    assert_reject_keeps_ctrl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !accept) |=> $stable(ctrl));

    assert_no_tick_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(count) && $stable(running)));

    assert_nmi_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi) |-> ($past(tick) && $past(running)));
endmodule

bind kwdog_top kwdog_checker #(.REG_W(REG_W), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .tick    (tick),
    .accept  (wr_accept),
    .ctrl    (st_q.ctrl),
    .count   (cnt_q),
    .running (run_q),
    .nmi     (nmi),
    .rst_req (rst_req)
);

// File: tb/kwdog_top_tb.sv
module kwdog_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GRACE      = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic        nmi;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    logic [31:0] m_ctrl;
    int          m_cnt;
    bit          m_run, m_stage, m_nmi, m_rreq;
    logic [6:0]  key;

    always #(CLK_PERIOD/2) clk = ~clk;

    kwdog_top #(.GRACE(GRACE)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tick    (tick),
        .nmi     (nmi),
        .rst_req (rst_req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = 0; m_run = 0; m_stage = 0; m_nmi = 0; m_rreq = 0;
        end else begin
            m_rreq = 0;
            if (wr_en && (!m_ctrl[8] || wr_data[15:9] == ~m_ctrl[15:9])) begin
                m_ctrl  = wr_data;
                m_cnt   = (wr_data[7:0] == 0) ? 256 : int'(wr_data[7:0]);
                m_run   = wr_data[8];
                m_stage = 0;
                m_nmi   = 0;
            end else if (m_run && tick) begin
                if (m_cnt == 1) begin
                    if (!m_stage) begin
                        m_stage = 1; m_nmi = 1; m_cnt = GRACE;
                    end else begin
                        m_rreq = 1; m_run = 0;
                    end
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (nmi !== m_nmi || rst_req !== m_rreq) begin
                errors++;
                $display("FAIL %s model compare: nmi=%b rst_req=%b expected nmi=%b rst_req=%b",
                         cur_req, nmi, rst_req, m_nmi, m_rreq);
            end
        end
    end

    task automatic check(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int cnt, input bit cmd, input logic [6:0] k);
        return {16'h0, k, cmd, cnt[7:0]};
    endfunction

    task automatic cyc(input bit t, input bit w, input logic [31:0] d);
        tick = t; wr_en = w; wr_data = d;
        @(negedge clk);
        tick = 0; wr_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "nmi in reset", nmi, 1'b0);
        check("R1", "rst_req in reset", rst_req, 1'b0);
        rst_n = 1'b1;
        idle(1);
        ticks(20);
        check("R1", "no expiry after reset", nmi, 1'b0);

        // R11: disabled, any key accepted; R4: count 5
        cur_req = "R11";
        key = 7'h15;
        cyc(0, 1, mk(5, 1, key));
        cur_req = "R4";
        ticks(4);
        check("R4", "nmi before count-th tick", nmi, 1'b0);
        ticks(1);
        check("R8", "nmi on first expiry", nmi, 1'b1);
        cur_req = "R8";
        ticks(GRACE - 1);
        check("R8", "grace still running, no reset", rst_req, 1'b0);

        // R10: correct kick clears nmi
        cur_req = "R10";
        key = ~key;
        cyc(0, 1, mk(3, 1, key));
        check("R10", "nmi cleared by kick", nmi, 1'b0);

        // R3: wrong key while enabled is dropped
        cur_req = "R3";
        ticks(1);
        cyc(0, 1, mk(3, 0, key));
        check("R3", "nmi after rejected write", nmi, 1'b0);
        ticks(1);
        check("R3", "nmi one tick early", nmi, 1'b0);
        ticks(1);
        check("R3", "expiry time kept", nmi, 1'b1);

        // R9: second expiry
        cur_req = "R9";
        ticks(GRACE - 1);
        check("R9", "no reset before grace end", rst_req, 1'b0);
        ticks(1);
        check("R9", "reset request pulse", rst_req, 1'b1);
        check("R9", "nmi held with reset", nmi, 1'b1);
        idle(1);
        check("R9", "reset request one cycle", rst_req, 1'b0);
        ticks(30);
        check("R9", "no further reset request", rst_req, 1'b0);
        check("R9", "nmi still held", nmi, 1'b1);

        // R6: stop command
        cur_req = "R6";
        key = ~key;
        cyc(0, 1, mk(4, 0, key));
        check("R6", "nmi cleared by stop write", nmi, 1'b0);
        ticks(300);
        check("R6", "stopped counter never expires", nmi, 1'b0);

        // R11 again and R5: count 0 means 256
        cur_req = "R5";
        key = 7'h00;
        cyc(0, 1, mk(0, 1, key));
        ticks(255);
        check("R5", "no expiry at 255 ticks", nmi, 1'b0);
        ticks(1);
        check("R5", "expiry at 256 ticks", nmi, 1'b1);

        // R7: only tick cycles count
        cur_req = "R7";
        key = ~key;
        cyc(0, 1, mk(4, 1, key));
        for (int i = 0; i < 3; i++) begin
            ticks(1);
            idle(5);
        end
        check("R7", "three spaced ticks, no expiry", nmi, 1'b0);
        idle(20);
        check("R7", "idle cycles do not count", nmi, 1'b0);
        ticks(1);
        check("R7", "fourth tick expires", nmi, 1'b1);

        // R12: write and tick together
        cur_req = "R12";
        key = ~key;
        cyc(0, 1, mk(2, 1, key));
        ticks(1);
        key = ~key;
        cyc(1, 1, mk(2, 1, key));
        ticks(1);
        check("R12", "tick with write not counted", nmi, 1'b0);
        ticks(1);
        check("R12", "expiry two ticks after write", nmi, 1'b1);

        // R2: upper bits ignored
        cur_req = "R2";
        key = ~key;
        cyc(0, 1, mk(2, 1, key) | 32'hFFFF_0000);
        check("R2", "kick with upper bits accepted", nmi, 1'b0);
        ticks(1);
        check("R2", "count field from [7:0]", nmi, 1'b0);
        ticks(1);
        check("R2", "expiry at written count", nmi, 1'b1);

        idle(2);
        finish_run();
    end
endmodule